// File: doc/BRIEF.md
# Factory Bad Block Scanner

This block runs once after power-up, before the flash is handed to the address-mapping logic. A single start pulse makes it visit every erase block in turn, lowest block number first. It fetches the first byte of the spare area from page 0 of each block, and if needed from page 1, through a simple page-read request/response port. Any such byte that is not the erased value FFh marks the block as factory-defective.

Each block ends in exactly one write to an external one-bit-per-block defect bitmap. A following mapping stage uses that bitmap to steer around bad blocks. While it runs, the scanner keeps a saturating tally of defective blocks. It raises a flag when the tally goes past the vendor's allowance, and a separate flag when block 0, which should always be good, turns out to be bad. A one-cycle done pulse closes the scan.

Top module: `bbs_scanner`

## Requirements
- R1: After reset the block is idle: busy, done, rd_req and bm_we are low, and bad_count, over_limit and blk0_bad are zero.
- R2: Blocks are scanned in ascending order. Each request carries row = block × 2^PAGE_BITS + page, with page 0 or 1, and always carries column SPARE_COL (2048 by default). Only one request is outstanding at a time.
- R3: If the returned page-0 byte is not FFh, the block is recorded as bad and no page-1 read is issued for it (SKIP_P1 = 1).
- R4: If page 0 returns FFh, page 1 is read. The block is bad if that byte is not FFh, and good if both bytes are FFh. Any single differing bit counts as a difference.
- R5: Every block gets exactly one bitmap write, with bm_addr equal to the block number and bm_bad = 1 for defective and 0 for good.
- R6: bad_count counts defective blocks and saturates at 2^CNT_W − 1 instead of wrapping.
- R7: over_limit is high whenever bad_count exceeds MAX_BAD.
- R8: blk0_bad goes high when block 0 is found defective, and stays low otherwise.
- R9: done is high for exactly one cycle, in the same cycle as the last block's bitmap write. bad_count is already final in that cycle, and busy falls in the cycle after it.
- R10: A start pulse while a scan is busy is ignored. A start pulse while idle clears bad_count, over_limit and blk0_bad and begins a new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a scan |
| rd_req | output | 1 | Page-read request strobe, one cycle |
| rd_row | output | BLK_W+PAGE_BITS | Row (block and page) of the request |
| rd_col | output | COL_W | Column of the requested byte |
| rsp_valid | input | 1 | Returned byte is valid |
| rsp_data | input | DATA_W | Returned byte |
| bm_we | output | 1 | Bitmap write strobe |
| bm_addr | output | BLK_W | Block number being written |
| bm_bad | output | 1 | 1 = defective, 0 = usable |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| bad_count | output | CNT_W | Saturating defective-block tally |
| over_limit | output | 1 | Tally exceeds MAX_BAD |
| blk0_bad | output | 1 | Block 0 found defective |

## Verification
The last block's bitmap write, the final tally increment and the done pulse all land in the same cycle. To provoke this, the bench uses patterns in which the highest block is bad only through its page-1 byte, so the final decision is also an increment. It then judges, in the done cycle, that bad_count already holds the full expected total and that the recorded bitmap includes the last entry. A second collision comes from a start pulse arriving in the middle of a scan. The bench judges that one by requiring the read count, write count and bitmap to match a single undisturbed scan exactly.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_REQ  = 2'd1,
      S_WAIT = 2'd2,
      S_FIN  = 2'd3
   } scan_st_t;

endpackage

// File: rtl/bbs_row_gen.sv
module bbs_row_gen #(
   parameter int BLK_W     = 11,
   parameter int PAGE_BITS = 6
) (
   input  logic [BLK_W-1:0]           blk,
   input  logic                       pg,
   output logic [BLK_W+PAGE_BITS-1:0] row
);
   localparam int ROW_W = BLK_W + PAGE_BITS;

   generate
      if (PAGE_BITS < 1) begin : g_bad_pb
         $error("bbs_row_gen: PAGE_BITS must be at least 1");
      end
   endgenerate

   always_comb begin
      row = {blk, {PAGE_BITS{1'b0}}};
      row = row | ROW_W'(pg);
   end
endmodule

// File: rtl/bbs_bad_tally.sv
module bbs_bad_tally #(
   parameter int CNT_W   = 12,
   parameter int MAX_BAD = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             over
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("bbs_bad_tally: CNT_W must be at least 1");
      end
      if (MAX_BAD >= (2 ** CNT_W) - 1) begin : g_bad_lim
         $error("bbs_bad_tally: MAX_BAD must be below the counter ceiling");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (inc && count != CNT_MAX) begin
         count <= count + 1'b1;
      end
   end

   assign over = (count > CNT_W'(MAX_BAD));

   // R6: once at the ceiling, the tally stays there until cleared
   a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_MAX && !clr) |=> count == CNT_MAX);

   // R6: without a clear the tally never goes down
   a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> count >= $past(count));
endmodule

// File: rtl/bbs_scanner.sv
module bbs_scanner
   import bbs_pkg::*;
#(
   parameter int          N_BLOCKS  = 2048,
   parameter int          PAGE_BITS = 6,
   parameter int          COL_W     = 12,
   parameter int          SPARE_COL = 2048,
   parameter int          DATA_W    = 8,
   parameter int          CNT_W     = 12,
   parameter int          MAX_BAD   = 40,
   parameter bit          SKIP_P1   = 1'b1,
   localparam int         BLK_W     = $clog2(N_BLOCKS),
   localparam int         ROW_W     = BLK_W + PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              rd_req,
   output logic [ROW_W-1:0]  rd_row,
   output logic [COL_W-1:0]  rd_col,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              bm_we,
   output logic [BLK_W-1:0]  bm_addr,
   output logic              bm_bad,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  bad_count,
   output logic              over_limit,
   output logic              blk0_bad
);
   localparam logic [BLK_W-1:0]  LAST_BLK = BLK_W'(N_BLOCKS - 1);
   localparam logic [DATA_W-1:0] ERASED   = {DATA_W{1'b1}};

   generate
      if (N_BLOCKS < 2) begin : g_bad_nb
         $error("bbs_scanner: N_BLOCKS must be at least 2");
      end
      if (SPARE_COL >= (2 ** COL_W)) begin : g_bad_col
         $error("bbs_scanner: SPARE_COL does not fit in COL_W");
      end
   endgenerate

   scan_st_t         st;
   logic [BLK_W-1:0] blk;
   logic             pg;
   logic             seen_bad;
   logic             byte_bad;
   logic             go_p1;
   logic             blk_bad;
   logic             decide;
   logic             tally_inc;
   logic             tally_clr;

   assign byte_bad = (rsp_data != ERASED);
   assign blk_bad  = byte_bad | seen_bad;

   generate
      if (SKIP_P1) begin : g_skip
         assign go_p1 = ~pg & ~byte_bad;
      end else begin : g_full
         assign go_p1 = ~pg;
      end
   endgenerate

   assign decide    = (st == S_WAIT) && rsp_valid && !go_p1;
   assign tally_inc = decide && blk_bad;
   assign tally_clr = (st == S_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         blk      <= '0;
         pg       <= 1'b0;
         seen_bad <= 1'b0;
         bm_we    <= 1'b0;
         bm_addr  <= '0;
         bm_bad   <= 1'b0;
         blk0_bad <= 1'b0;
      end else begin
         bm_we <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  st       <= S_REQ;
                  blk      <= '0;
                  pg       <= 1'b0;
                  seen_bad <= 1'b0;
                  blk0_bad <= 1'b0;
               end
            end
            S_REQ: st <= S_WAIT;
            S_WAIT: begin
               if (rsp_valid) begin
                  if (go_p1) begin
                     pg       <= 1'b1;
                     seen_bad <= byte_bad;
                     st       <= S_REQ;
                  end else begin
                     bm_we    <= 1'b1;
                     bm_addr  <= blk;
                     bm_bad   <= blk_bad;
                     if (blk == '0 && blk_bad) blk0_bad <= 1'b1;
                     pg       <= 1'b0;
                     seen_bad <= 1'b0;
                     if (blk == LAST_BLK) begin
                        st <= S_FIN;
                     end else begin
                        blk <= blk + 1'b1;
                        st  <= S_REQ;
                     end
                  end
               end
            end
            S_FIN:   st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   bbs_row_gen #(.BLK_W(BLK_W), .PAGE_BITS(PAGE_BITS)) u_row (
      .blk (blk),
      .pg  (pg),
      .row (rd_row)
   );

   bbs_bad_tally #(.CNT_W(CNT_W), .MAX_BAD(MAX_BAD)) u_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tally_clr),
      .inc   (tally_inc),
      .count (bad_count),
      .over  (over_limit)
   );

   assign rd_req = (st == S_REQ);
   assign rd_col = COL_W'(SPARE_COL);
   assign busy   = (st != S_IDLE);
   assign done   = (st == S_FIN);

   // R2: a request is never followed by another before its answer
   a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R5: bitmap writes only happen inside a scan
   a_r5_write_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
      bm_we |-> busy);

   // R8: the block-0 flag rises only together with a bad write to entry 0
   a_r8_blk0_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blk0_bad) |-> (bm_we && bm_addr == '0 && bm_bad));

   // R9: done lasts one cycle and the scan is over afterwards
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R9: done coincides with the final bitmap write
   a_r9_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bm_we && bm_addr == LAST_BLK));

   // R10: a start during a running scan does not restart or stop it
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start) |=> busy);
endmodule

// File: tb/sim_bbs_scanner.sv
module sim_bbs_scanner;
   localparam int NB    = 16;
   localparam int PB    = 6;
   localparam int CW    = 12;
   localparam int BW    = $clog2(NB);
   localparam int RW    = BW + PB;
   localparam int NCW   = 3;
   localparam int MAXB  = 3;
   localparam int NVEC  = 8;

   // {page0 bad mask, page1 bad mask, expected count, 6'b0, over, blk0}
   localparam logic [47:0] VEC [NVEC] = '{
      {16'h0000, 16'h0000, 8'd0, 8'h00},
      {16'h0001, 16'h0000, 8'd1, 8'h01},
      {16'h0000, 16'h8000, 8'd1, 8'h00},
      {16'h00F0, 16'h0F00, 8'd7, 8'h02},
      {16'h0000, 16'h0000, 8'd0, 8'h00},
      {16'h0003, 16'h0006, 8'd3, 8'h01},
      {16'h000F, 16'h8010, 8'd6, 8'h03},
      {16'h0101, 16'h0101, 8'd2, 8'h01}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            rd_req;
   logic [RW-1:0]   rd_row;
   logic [CW-1:0]   rd_col;
   logic            rsp_valid;
   logic [7:0]      rsp_data;
   logic            bm_we;
   logic [BW-1:0]   bm_addr;
   logic            bm_bad;
   logic            busy;
   logic            done;
   logic [NCW-1:0]  bad_count;
   logic            over_limit;
   logic            blk0_bad;

   always #5 clk = ~clk;

   bbs_scanner #(
      .N_BLOCKS(NB), .PAGE_BITS(PB), .COL_W(CW), .SPARE_COL(2048),
      .DATA_W(8), .CNT_W(NCW), .MAX_BAD(MAXB), .SKIP_P1(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rd_req(rd_req), .rd_row(rd_row), .rd_col(rd_col),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .bm_we(bm_we), .bm_addr(bm_addr), .bm_bad(bm_bad),
      .busy(busy), .done(done), .bad_count(bad_count),
      .over_limit(over_limit), .blk0_bad(blk0_bad)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   logic [15:0] p0m = '0;
   logic [15:0] p1m = '0;
   logic [15:0] bm_seen;
   int          writes;
   int          reads;
   int          order_err;
   int          last_blk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // flash read model and bitmap monitor
   initial begin : responder
      bit          pend;
      int          wait_cnt;
      logic [RW-1:0] row_l;
      rsp_valid = 1'b0;
      rsp_data  = 8'h00;
      pend      = 1'b0;
      wait_cnt  = 0;
      row_l     = '0;
      forever begin
         @(negedge clk);
         if (rsp_valid) rsp_valid = 1'b0;
         if (bm_we) begin
            bm_seen[bm_addr] = bm_bad;
            writes++;
         end
         if (rd_req) begin
            int b;
            int p;
            reads++;
            row_l = rd_row;
            b = int'(rd_row >> PB);
            p = int'(rd_row[PB-1:0]);
            if (rd_col != CW'(2048) || p > 1 || b < last_blk) order_err++;
            last_blk = b;
            pend = 1'b1;
            wait_cnt = 1 + int'(rd_row % 3);
         end else if (pend) begin
            wait_cnt--;
            if (wait_cnt == 0) begin
               int b;
               int p;
               bit bad;
               b = int'(row_l >> PB);
               p = int'(row_l[PB-1:0]);
               bad = (p == 0) ? p0m[b] : p1m[b];
               if (p > 1) rsp_data = 8'h00;
               else if (bad) rsp_data = b[0] ? 8'hFE : 8'h7F;
               else rsp_data = 8'hFF;
               rsp_valid = 1'b1;
               pend = 1'b0;
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog expired, scan never completed");
      finish_run();
   end

   task automatic run_scan(input logic [15:0] m0, input logic [15:0] m1,
                           input bit restart_mid);
      p0m = m0;
      p1m = m1;
      @(negedge clk);
      bm_seen   = '0;
      writes    = 0;
      reads     = 0;
      order_err = 0;
      last_blk  = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (restart_mid) begin
         repeat (20) @(negedge clk);
         chk(busy == 1'b1, "R10 busy before mid-scan start", int'(busy), 1);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk(busy == 1'b1, "R10 still busy after mid-scan start", int'(busy), 1);
      end
      while (!done) @(negedge clk);
   endtask

   initial begin : main
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!busy && !done && !rd_req && !bm_we, "R1 idle during reset", int'({busy, done, rd_req, bm_we}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !done && !rd_req && !bm_we, "R1 idle after reset", int'({busy, done, rd_req, bm_we}), 0);
      chk(bad_count == '0 && !over_limit && !blk0_bad, "R1 status cleared", int'({bad_count, over_limit, blk0_bad}), 0);

      for (int v = 0; v < NVEC; v++) begin
         logic [15:0] m0;
         logic [15:0] m1;
         logic [15:0] expmap;
         int          ecount;
         m0 = VEC[v][47:32];
         m1 = VEC[v][31:16];
         ecount = int'(VEC[v][15:8]);
         expmap = m0 | m1;
         run_scan(m0, m1, 1'b0);
         // done cycle: tally final, last write present alongside done (R9)
         chk(int'(bad_count) == ecount, "R6 count at done", int'(bad_count), ecount);
         chk(over_limit == VEC[v][1], "R7 over_limit", int'(over_limit), int'(VEC[v][1]));
         chk(blk0_bad == VEC[v][0], "R8 blk0 flag", int'(blk0_bad), int'(VEC[v][0]));
         @(negedge clk);
         chk(!done && !busy, "R9 done one cycle", int'({done, busy}), 0);
         chk(writes == NB, "R5 one write per block", writes, NB);
         chk(bm_seen == expmap, "R4 bitmap contents", int'(bm_seen), int'(expmap));
         chk(reads == 2 * NB - $countones(m0), "R3 page1 skipped on bad page0", reads, 2 * NB - $countones(m0));
         chk(order_err == 0, "R2 ascending rows at column 2048", order_err, 0);
      end

      // R10: start while busy is ignored; results match one clean scan
      run_scan(16'h00F0, 16'h0F00, 1'b1);
      chk(int'(bad_count) == 7, "R10 count after mid-scan start", int'(bad_count), 7);
      @(negedge clk);
      chk(writes == NB, "R10 writes after mid-scan start", writes, NB);
      chk(reads == 28, "R10 reads after mid-scan start", reads, 28);
      chk(bm_seen == 16'h0FF0, "R10 bitmap after mid-scan start", int'(bm_seen), 16'h0FF0);

      // R10: idle start clears status; R6 saturated value does not wrap
      run_scan(16'hFFFF, 16'h0000, 1'b0);
      chk(int'(bad_count) == 7, "R6 saturation at 7", int'(bad_count), 7);
      @(negedge clk);
      chk(reads == NB, "R3 all page1 reads skipped", reads, NB);
      run_scan(16'h0000, 16'h0000, 1'b0);
      chk(bad_count == '0 && !over_limit && !blk0_bad, "R10 idle start clears status",
          int'({bad_count, over_limit, blk0_bad}), 0);

      finish_run();
   end
endmodule